// File: doc/BRIEF.md
# Remote Core Reset and Boot Controller

This block lets one processor core drive the reset of a second core and pick how that second core starts. Software on the controlling core writes a small control register. Setting the reset-request bit puts the target core into hardware reset. A separate hold bit keeps the target in reset until software boots it. The boot selection is a two-bit field in the same register. It reaches the target core only when the reset is released, so software can stage it in advance.

A status register reports two events through sticky pending bits. The first sets when the target core acknowledges that it is in reset. The second sets when the target core has come back out of reset. Software clears each one by writing 1 to it. Each event can also drive a shared interrupt line. The target core can refuse a reset by raising its mask input. While that input is high, a request is not acted on.

The control and status pins are plain levels. The block carries no data stream, so it has no valid/ready handshake. A register write takes effect on the clock edge where `reg_wr_en` is sampled high. Both registers can be read at all times on their own output buses.

Top module: `remote_reset_ctrl`

## Requirements
- R1: After reset, `core_rst_o`, `core_boot_o`, `irq_o`, `ctrl_rd` and `stat_rd` are all zero.
- R2: Control bit 0 is the reset request. When it is written to 1 while `core_mask_i` is low, `core_rst_o` rises one clock after the register update. Status bit 2 mirrors `core_rst_o`. The reset output stays high for as long as control bit 0 or control bit 1 (hold) is set.
- R3: Once a request is taken, `core_rst_o` stays high for at least MIN_RST_CYC cycles (default 8), even if the request bit is cleared at once.
- R4: Status bit 0 (entered-reset pending) sets when `core_ack_i` is high while `core_rst_o` is asserted.
- R5: On release, `core_rst_o` falls and `core_boot_o` takes control bits [3:2] in the same cycle. Status bit 1 (left-reset pending) then sets once `core_ack_i` is low.
- R6: With hold (control bit 1) set, clearing the request bit does not release the core. A later write with both bits clear and a new boot field releases the core and boots it in that mode.
- R7: Writing status (address 1) clears each pending bit written with 1 and leaves the bits written with 0 unchanged.
- R8: While `core_mask_i` is high, a request asserts no reset and sets no entered-reset pending bit. If the request is still set when the mask drops, the reset is then taken.
- R9: Control writes made outside a release do not change `core_boot_o`.
- R10: `irq_o` is high when status bit 0 is set together with control bit 4, or when status bit 1 is set together with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wr_data | input | REG_W | Write data |
| ctrl_rd | output | REG_W | Control register contents |
| stat_rd | output | REG_W | Status register contents |
| irq_o | output | 1 | Pending-event interrupt |
| core_rst_o | output | 1 | Reset to the target core, active high |
| core_boot_o | output | BOOT_W | Boot mode presented to the target core |
| core_mask_i | input | 1 | Target core refuses reset requests |
| core_ack_i | input | 1 | Target core reports that it is in reset |

## Verification
A short request pulse shows that the minimum reset width governs the release, not the width of the request bit. It also shows that the boot field reaches the target at that release. A held sequence shows that a cleared request alone cannot free the core and that the later boot write does. The masked pattern tells a refused request apart from one that is only delayed: nothing happens under the mask, and the reset is taken as soon as the mask falls. Write-1-to-clear writes and enable combinations then separate the two pending sources, both in the status register and on the interrupt.

// File: rtl/rrc_pkg.sv
`timescale 1ns/1ps
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_EXIT = 2'd2
  } rrc_state_e;

  localparam int unsigned CTRL_REQ  = 0;
  localparam int unsigned CTRL_HOLD = 1;
  localparam int unsigned CTRL_BOOT = 2;

  localparam int unsigned STAT_ENTER  = 0;
  localparam int unsigned STAT_LEAVE  = 1;
  localparam int unsigned STAT_ACTIVE = 2;
  localparam int unsigned NUM_PEND    = 2;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/rrc_pend_bit.sv
`timescale 1ns/1ps
module rrc_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/rrc_regfile.sv
`timescale 1ns/1ps
module rrc_regfile
  import rrc_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned BOOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              set_enter,
  input  logic              set_leave,
  input  logic              core_active,
  output logic              req,
  output logic              hold,
  output logic [BOOT_W-1:0] boot_field,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  stat_q,
  output logic              irq
);
  localparam int unsigned IE_BASE   = CTRL_BOOT + BOOT_W;
  localparam int unsigned CTRL_USED = IE_BASE + NUM_PEND;
  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((1 << CTRL_USED) - 1);

  logic [NUM_PEND-1:0] pend;
  logic [NUM_PEND-1:0] pend_set;
  logic [NUM_PEND-1:0] irq_src;
  logic                stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data & CTRL_MASK;
  end

  assign stat_wr  = wr_en && (wr_addr == ADDR_STAT);
  assign pend_set = {set_leave, set_enter};

  for (genvar i = 0; i < NUM_PEND; i++) begin : g_pend
    rrc_pend_bit u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pend_set[i]),
      .clr_i  (stat_wr && wr_data[i]),
      .pend_o (pend[i])
    );
    assign irq_src[i] = pend[i] && ctrl_q[IE_BASE + i];
  end

  always_comb begin
    stat_q              = '0;
    stat_q[NUM_PEND-1:0] = pend;
    stat_q[STAT_ACTIVE] = core_active;
  end

  assign req        = ctrl_q[CTRL_REQ];
  assign hold       = ctrl_q[CTRL_HOLD];
  assign boot_field = ctrl_q[CTRL_BOOT +: BOOT_W];
  assign irq        = |irq_src;
endmodule

// File: rtl/rrc_sequencer.sv
`timescale 1ns/1ps
module rrc_sequencer
  import rrc_pkg::*;
#(
  parameter int unsigned BOOT_W      = 2,
  parameter int unsigned MIN_RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              hold,
  input  logic [BOOT_W-1:0] boot_field,
  input  logic              mask_i,
  input  logic              ack_i,
  output logic              core_rst,
  output logic [BOOT_W-1:0] boot_q,
  output logic              set_enter,
  output logic              set_leave
);
  localparam int unsigned CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_RST_CYC - 1);

  rrc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             ack_seen;
  logic             may_release;

  assign may_release = (cnt == CNT_LAST) && !req && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ack_seen <= 1'b0;
      boot_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req && !mask_i) begin
            state    <= ST_HELD;
            cnt      <= '0;
            ack_seen <= 1'b0;
          end
        end
        ST_HELD: begin
          if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
          if (ack_i)           ack_seen <= 1'b1;
          if (may_release) begin
            state  <= ST_EXIT;
            boot_q <= boot_field;
          end
        end
        ST_EXIT: begin
          if (!ack_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign core_rst  = (state == ST_HELD);
  assign set_enter = (state == ST_HELD) && ack_i && !ack_seen;
  assign set_leave = (state == ST_EXIT) && !ack_i;
endmodule

// File: rtl/remote_reset_ctrl.sv
`timescale 1ns/1ps
module remote_reset_ctrl #(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned BOOT_W      = 2,
  parameter int unsigned MIN_RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  ctrl_rd,
  output logic [REG_W-1:0]  stat_rd,
  output logic              irq_o,
  output logic              core_rst_o,
  output logic [BOOT_W-1:0] core_boot_o,
  input  logic              core_mask_i,
  input  logic              core_ack_i
);
  logic              req;
  logic              hold;
  logic [BOOT_W-1:0] boot_field;
  logic              set_enter;
  logic              set_leave;

  rrc_regfile #(
    .REG_W  (REG_W),
    .BOOT_W (BOOT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .wr_addr     (reg_wr_addr),
    .wr_data     (reg_wr_data),
    .set_enter   (set_enter),
    .set_leave   (set_leave),
    .core_active (core_rst_o),
    .req         (req),
    .hold        (hold),
    .boot_field  (boot_field),
    .ctrl_q      (ctrl_rd),
    .stat_q      (stat_rd),
    .irq         (irq_o)
  );

  rrc_sequencer #(
    .BOOT_W      (BOOT_W),
    .MIN_RST_CYC (MIN_RST_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .hold       (hold),
    .boot_field (boot_field),
    .mask_i     (core_mask_i),
    .ack_i      (core_ack_i),
    .core_rst   (core_rst_o),
    .boot_q     (core_boot_o),
    .set_enter  (set_enter),
    .set_leave  (set_leave)
  );
endmodule

// File: rtl/rrc_checker.sv
`timescale 1ns/1ps
module rrc_checker #(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned BOOT_W      = 2,
  parameter int unsigned MIN_RST_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  ctrl_rd,
  input logic [REG_W-1:0]  stat_rd,
  input logic              core_rst_o,
  input logic [BOOT_W-1:0] core_boot_o,
  input logic              core_mask_i
);
  localparam int unsigned RUN_W = $clog2(MIN_RST_CYC + 1);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run <= '0;
    else if (!core_rst_o)        run <= '0;
    else if (run != RUN_W'(MIN_RST_CYC)) run <= run + 1'b1;
  end

  // R3
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (run == RUN_W'(MIN_RST_CYC)));

  // R2
  held_while_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_o && (ctrl_rd[0] || ctrl_rd[1])) |=> core_rst_o);

  // R8
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_mask_i && !core_rst_o) |=> !core_rst_o);

  // R9
  boot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(core_rst_o) |-> $stable(core_boot_o));

  // R4
  enter_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rd[0]) |-> $past(core_rst_o));

  // R5
  leave_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rd[1]) |-> !core_rst_o);
endmodule

bind remote_reset_ctrl rrc_checker #(
  .REG_W       (REG_W),
  .BOOT_W      (BOOT_W),
  .MIN_RST_CYC (MIN_RST_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_rd     (ctrl_rd),
  .stat_rd     (stat_rd),
  .core_rst_o  (core_rst_o),
  .core_boot_o (core_boot_o),
  .core_mask_i (core_mask_i)
);

// File: tb/remote_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module remote_reset_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic       reg_wr_addr = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] ctrl_rd;
  logic [7:0] stat_rd;
  logic       irq_o;
  logic       core_rst_o;
  logic [1:0] core_boot_o;
  logic       core_mask_i = 1'b0;
  logic       core_ack_i = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  int hi_cnt   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  // stand-in target core: acknowledges reset one cycle late
  always_ff @(posedge clk) core_ack_i <= core_rst_o;

  always @(negedge clk) if (core_rst_o) hi_cnt++;

  remote_reset_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .ctrl_rd     (ctrl_rd),
    .stat_rd     (stat_rd),
    .irq_o       (irq_o),
    .core_rst_o  (core_rst_o),
    .core_boot_o (core_boot_o),
    .core_mask_i (core_mask_i),
    .core_ack_i  (core_ack_i)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic addr, input logic [7:0] data);
    reg_wr_en   = 1'b1;
    reg_wr_addr = addr;
    reg_wr_data = data;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 core_rst_o", core_rst_o, 0);
    check("R1 core_boot_o", core_boot_o, 0);
    check("R1 irq_o", irq_o, 0);
    check("R1 ctrl_rd", ctrl_rd, 0);
    check("R1 stat_rd", stat_rd, 0);
  endtask

  task automatic t_short_pulse();
    hi_cnt = 0;
    wr(1'b0, 8'h09);                  // request, boot 2
    check("R2 not yet asserted", core_rst_o, 0);
    wr(1'b0, 8'h08);                  // drop request at once
    check("R2 asserted one cycle later", core_rst_o, 1);
    check("R2 status active bit", stat_rd[2], 1);
    wait_cyc(20);
    check("R3 minimum reset width", hi_cnt, 8);
    check("R5 boot mode on release", core_boot_o, 2);
    check("R4 R5 both pending bits", stat_rd, 8'h03);
  endtask

  task automatic t_w1c();
    wr(1'b1, 8'h01);
    check("R7 clear entered only", stat_rd, 8'h02);
    wr(1'b1, 8'h00);
    check("R7 zero write keeps bit", stat_rd, 8'h02);
    wr(1'b1, 8'h02);
    check("R7 clear left", stat_rd, 8'h00);
  endtask

  task automatic t_hold_boot();
    wr(1'b0, 8'h03);                  // request + hold
    wait_cyc(20);
    check("R2 held under request", core_rst_o, 1);
    check("R4 entered pending", stat_rd, 8'h05);
    wr(1'b0, 8'h02);                  // drop request, keep hold
    wait_cyc(15);
    check("R6 hold keeps reset", core_rst_o, 1);
    check("R6 no left pending while held", stat_rd[1], 0);
    check("R9 boot not changed while held", core_boot_o, 2);
    wr(1'b0, 8'h04);                  // boot 1, release
    wait_cyc(6);
    check("R6 released by boot write", core_rst_o, 0);
    check("R6 booted mode", core_boot_o, 1);
    check("R5 left pending", stat_rd, 8'h03);
    wr(1'b0, 8'h0C);                  // new boot field, no request
    wait_cyc(4);
    check("R9 boot output unchanged", core_boot_o, 1);
    check("R9 no reset from boot field", core_rst_o, 0);
    wr(1'b1, 8'h03);
  endtask

  task automatic t_mask();
    core_mask_i = 1'b1;
    wr(1'b0, 8'h01);
    wait_cyc(15);
    check("R8 masked request no reset", core_rst_o, 0);
    check("R8 masked no entered pending", stat_rd, 8'h00);
    core_mask_i = 1'b0;
    wait_cyc(3);
    check("R8 taken after mask drops", core_rst_o, 1);
    wr(1'b0, 8'h00);
    wait_cyc(15);
    check("R8 released", core_rst_o, 0);
    check("R8 both pending after release", stat_rd, 8'h03);
  endtask

  task automatic t_irq();
    check("R10 no enables", irq_o, 0);
    wr(1'b0, 8'h10);
    check("R10 entered enabled", irq_o, 1);
    wr(1'b1, 8'h01);
    check("R10 entered cleared", irq_o, 0);
    wr(1'b0, 8'h20);
    check("R10 left enabled", irq_o, 1);
    wr(1'b0, 8'h10);
    check("R10 left disabled", irq_o, 0);
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h02);
    check("R10 left cleared", irq_o, 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset_state();
    t_short_pulse();
    t_w1c();
    t_hold_boot();
    t_mask();
    t_irq();
    done = 1;
    report();
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule